// File: doc/BRIEF.md
# Per-Timeslot Channel Control Datapath

This block sits between a backplane byte stream and a line-side byte stream of a 24-slot framed link. Every cycle with `byte_vld` high carries one timeslot: one backplane byte heading for the line and one line byte heading for the backplane. An internal slot counter runs 0..23 and wraps. Each wrap advances a signaling-frame counter (0..5) and a test-tone index (0..7). Each slot has an 8-bit control word. The words live in a 24-entry table written through a simple address/data/write-enable port. One control word sets how that slot is built in both directions.

The control word, MSB to LSB, is: message (bit 7), invert (bit 6), remote loop (bit 5), local loop (bit 4), transmit test (bit 3), receive test (bit 2), signaling-from-RAM (bit 1), clear channel (bit 0). Two selector enumerations are decoded from the word.

The transmit selector takes one of four states, highest first:
- `TX_LOOP` returns the received line byte.
- `TX_TEST` sends a test byte.
- `TX_MSG` sends the shared message byte.
- `TX_NORMAL` sends the backplane byte, inverted when the invert bit is set.

The receive selector takes one of three states, highest first:
- `RX_LOOP` returns the final transmit byte.
- `RX_TEST` sends the test tone.
- `RX_NORMAL` sends the line byte, inverted when the invert bit is set.

The test signal is an 8-byte repeating tone when `dmw_sel` is 1, and a 2^15-1 pseudo-random sequence (x^15+x^14+1) when `dmw_sel` is 0.

The pseudo-random checker is a two-state machine. `CHK_LOAD` shifts in the first 15 received bits, then takes the transition LOAD->RUN. `CHK_RUN` compares each later bit with the XOR of the bits 15 and 14 positions earlier. It counts mismatches and stays in RUN until reset.

Top module: `tslot_ctl_path`

## Requirements
- R1: After reset, `line_tx_byte`, `bp_rx_byte`, `out_slot`, `out_vld`, `prbs_err_cnt`, `prbs_locked` and every control word read 0. The first valid byte belongs to slot 0, signaling frame 0, tone index 0.
- R2: A write at `cfg_addr` 0..23 stores `cfg_wdata` and is visible on `cfg_rdata` (combinational read) from the next cycle. Writes at addresses 24..31 are dropped, and reads there return 0.
- R3: With the message bit (7) set and no higher transmit source, the slot's line byte equals `msg_byte`.
- R4: With the invert bit (6) set, the slot's line byte is the complement of the backplane byte, and the slot's backplane byte is the complement of the line byte, when no higher source applies in that direction.
- R5: With the remote-loop bit (5) set, the slot's line byte equals the received line byte. The backplane side still receives the line byte as normal.
- R6: With the local-loop bit (4) set, the slot's backplane byte equals the slot's final line byte, which is still sent on the line.
- R7: With the transmit-test bit (3) set, the line byte is a test byte. With `dmw_sel`=1 it is tone entry `frame mod 8`: 1E 0B 0B 1E 9E 8B 8B 9E. With `dmw_sel`=0 it is the next 8 generator bits, MSB first, from an all-ones seed. The generator advances only on such bytes, and several slots may draw from it in turn.
- R8: With the receive-test bit (2) set and `dmw_sel`=1, the backplane byte is the current tone entry. With `dmw_sel`=0, the slot's line byte (MSB first) is fed to the checker and the backplane byte stays normal.
- R9: In signaling frame 5 (every 6th frame), a slot with the clear-channel bit (0) at 0 has bit 0 of its final line byte replaced by a signaling bit. In other frames, or with the bit at 1, nothing is replaced.
- R10: The robbed bit is `sig_ser_bit` when control bit 1 is 0 and `sig_ram_bit` when it is 1.
- R11: When several transmit bits are set, the priority is remote loop, then test, then message, then invert. On the receive side the priority is local loop, then tone test, then invert.
- R12: The checker enters RUN after 15 loaded bits (`prbs_locked`=1). It counts each mismatch into a 16-bit count that saturates at FFFF. `err_clr` zeroes the count on the next cycle, taking precedence over that cycle's errors.
- R13: The outputs of a valid slot appear one cycle after `byte_vld`, with `out_vld`=1 and `out_slot` set to the slot number. On cycles without `byte_vld`, `out_vld` is 0 and both bytes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control-word write enable |
| cfg_addr | input | 5 | Control-word slot address |
| cfg_wdata | input | 8 | Control-word write data |
| cfg_rdata | output | 8 | Control word at `cfg_addr` |
| msg_byte | input | 8 | Shared message byte |
| dmw_sel | input | 1 | Test signal select: 1 tone, 0 pseudo-random |
| byte_vld | input | 1 | One timeslot present on the byte inputs |
| bp_tx_byte | input | 8 | Backplane byte for the line |
| line_rx_byte | input | 8 | Line byte for the backplane |
| sig_ser_bit | input | 1 | Signaling bit from the serial signaling stream |
| sig_ram_bit | input | 1 | Signaling bit from the processor-written RAM |
| err_clr | input | 1 | Clear the checker error count |
| line_tx_byte | output | 8 | Byte sent on the line |
| bp_rx_byte | output | 8 | Byte sent to the backplane |
| out_vld | output | 1 | Output bytes belong to a new slot |
| out_slot | output | 5 | Slot number of the output bytes |
| prbs_err_cnt | output | 16 | Saturating checker error count |
| prbs_locked | output | 1 | Checker is in RUN |

## Verification
A slip of the slot counter shows on `out_slot` in the very next valid cycle. Every later byte then takes the wrong control word, so a loop, message or inversion slot shows the wrong content at once. A wrong generator state shows in the next test byte, while a wrong tone index shows only in the next frame. A checker stuck in LOAD, or shifting a bit too few, shows within two test bytes as a missing lock or as a burst of error counts on clean data.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic msg;
        logic inv;
        logic rem_lp;
        logic loc_lp;
        logic tx_tst;
        logic rx_tst;
        logic sig_ram;
        logic clr_ch;
    } tsc_ctl_t;

    typedef enum logic {
        CHK_LOAD = 1'b0,
        CHK_RUN  = 1'b1
    } chk_state_t;

    typedef enum logic [1:0] {
        TX_NORMAL = 2'd0,
        TX_MSG    = 2'd1,
        TX_TEST   = 2'd2,
        TX_LOOP   = 2'd3
    } tx_src_t;

    typedef enum logic [1:0] {
        RX_NORMAL = 2'd0,
        RX_TEST   = 2'd1,
        RX_LOOP   = 2'd2
    } rx_src_t;

endpackage

// File: rtl/tsc_ctl_ram.sv
module tsc_ctl_ram
    import tsc_pkg::*;
#(
    parameter int unsigned SLOTS = 24,
    parameter int unsigned AW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rda_addr,
    output logic [BYTE_W-1:0] rda_data,
    input  logic [AW-1:0]     rdb_addr,
    output tsc_ctl_t          rdb_data
);
    localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

    logic [BYTE_W-1:0] word_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                word_q[g] <= wr_data;
        end
    end

    always_comb begin
        rda_data = (rda_addr <= LAST) ? word_q[rda_addr] : '0;
        rdb_data = (rdb_addr <= LAST) ? tsc_ctl_t'(word_q[rdb_addr]) : '0;
    end
endmodule

// File: rtl/tsc_prbs_gen.sv
module tsc_prbs_gen
    import tsc_pkg::*;
#(
    parameter int unsigned PW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [BYTE_W-1:0] byte_o
);
    logic [PW-1:0] st_q, st_n;
    logic          fb;

    always_comb begin
        st_n   = st_q;
        byte_o = '0;
        fb     = 1'b0;
        for (int i = 0; i < BYTE_W; i++) begin
            fb                 = st_n[PW-1] ^ st_n[PW-2];
            byte_o[BYTE_W-1-i] = fb;
            st_n               = {st_n[PW-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '1;
        else if (adv)
            st_q <= st_n;
    end
endmodule

// File: rtl/tsc_prbs_chk.sv
module tsc_prbs_chk
    import tsc_pkg::*;
#(
    parameter int unsigned PW    = 15,
    parameter int unsigned ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    input  logic              clr,
    output logic [ERR_W-1:0]  err_cnt,
    output logic              locked
);
    localparam int unsigned LW = $clog2(PW + 1);

    chk_state_t     state_q, state_n;
    logic [PW-1:0]  sh_q, sh_n;
    logic [LW-1:0]  ld_q, ld_n;
    logic [ERR_W-1:0] err_q, err_n;
    logic [3:0]     errs;
    logic [ERR_W:0] sum;
    logic           bit_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHK_LOAD;
            sh_q    <= '0;
            ld_q    <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_n;
            sh_q    <= sh_n;
            ld_q    <= ld_n;
            err_q   <= err_n;
        end
    end

    always_comb begin
        state_n = state_q;
        sh_n    = sh_q;
        ld_n    = ld_q;
        errs    = '0;
        bit_v   = 1'b0;
        if (en) begin
            for (int i = 0; i < BYTE_W; i++) begin
                bit_v = din[BYTE_W-1-i];
                unique case (state_n)
                    CHK_LOAD: begin
                        if (ld_n == LW'(PW - 1))
                            state_n = CHK_RUN;
                        ld_n = ld_n + 1'b1;
                    end
                    CHK_RUN: begin
                        if (bit_v != (sh_n[PW-1] ^ sh_n[PW-2]))
                            errs = errs + 4'd1;
                    end
                endcase
                sh_n = {sh_n[PW-2:0], bit_v};
            end
        end
        sum   = {1'b0, err_q} + {{(ERR_W-3){1'b0}}, errs};
        err_n = clr ? '0 : (sum[ERR_W] ? '1 : sum[ERR_W-1:0]);
    end

    assign err_cnt = err_q;
    assign locked  = (state_q == CHK_RUN);
endmodule

// File: rtl/tslot_ctl_path.sv
module tslot_ctl_path
    import tsc_pkg::*;
#(
    parameter int unsigned SLOTS      = 24,
    parameter int unsigned SIG_PERIOD = 6,
    parameter int unsigned PW         = 15,
    parameter int unsigned ERR_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [7:0]  msg_byte,
    input  logic        dmw_sel,
    input  logic        byte_vld,
    input  logic [7:0]  bp_tx_byte,
    input  logic [7:0]  line_rx_byte,
    input  logic        sig_ser_bit,
    input  logic        sig_ram_bit,
    input  logic        err_clr,
    output logic [7:0]  line_tx_byte,
    output logic [7:0]  bp_rx_byte,
    output logic        out_vld,
    output logic [4:0]  out_slot,
    output logic [15:0] prbs_err_cnt,
    output logic        prbs_locked
);
    localparam int unsigned AW = 5;
    localparam int unsigned FW = $clog2(SIG_PERIOD);
    localparam logic [AW-1:0] SLOT_LAST = AW'(SLOTS - 1);
    localparam logic [FW-1:0] SIG_LAST  = FW'(SIG_PERIOD - 1);

    logic [AW-1:0] slot_q;
    logic [FW-1:0] sigf_q;
    logic [2:0]    tone_q;
    tsc_ctl_t      slot_ctl;
    logic          sig_frame;
    logic [7:0]    prbs_byte, tone_byte, tx_byte, tx_fin, rx_byte;
    logic          sig_bit;
    tx_src_t       tx_src;
    rx_src_t       rx_src;
    logic [7:0]    line_tx_q, bp_rx_q;
    logic [AW-1:0] out_slot_q;
    logic          vld_q;

    function automatic logic [7:0] tone_at(input logic [2:0] idx);
        unique case (idx)
            3'd0: return 8'h1E;
            3'd1: return 8'h0B;
            3'd2: return 8'h0B;
            3'd3: return 8'h1E;
            3'd4: return 8'h9E;
            3'd5: return 8'h8B;
            3'd6: return 8'h8B;
            3'd7: return 8'h9E;
        endcase
    endfunction

    tsc_ctl_ram #(.SLOTS(SLOTS), .AW(AW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .rda_addr(cfg_addr), .rda_data(cfg_rdata),
        .rdb_addr(slot_q), .rdb_data(slot_ctl)
    );

    tsc_prbs_gen #(.PW(PW)) u_gen (
        .clk(clk), .rst_n(rst_n),
        .adv(byte_vld && slot_ctl.tx_tst && !dmw_sel),
        .byte_o(prbs_byte)
    );

    tsc_prbs_chk #(.PW(PW), .ERR_W(ERR_W)) u_chk_core (
        .clk(clk), .rst_n(rst_n),
        .en(byte_vld && slot_ctl.rx_tst && !dmw_sel),
        .din(line_rx_byte), .clr(err_clr),
        .err_cnt(prbs_err_cnt), .locked(prbs_locked)
    );

    // Slot and frame position register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            sigf_q <= '0;
            tone_q <= '0;
        end else if (byte_vld) begin
            if (slot_q == SLOT_LAST) begin
                slot_q <= '0;
                sigf_q <= (sigf_q == SIG_LAST) ? '0 : sigf_q + 1'b1;
                tone_q <= tone_q + 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign sig_frame = (sigf_q == SIG_LAST);
    assign tone_byte = tone_at(tone_q);
    assign sig_bit   = slot_ctl.sig_ram ? sig_ram_bit : sig_ser_bit;

    // Source selection, priority ordered
    always_comb begin
        if (slot_ctl.rem_lp)      tx_src = TX_LOOP;
        else if (slot_ctl.tx_tst) tx_src = TX_TEST;
        else if (slot_ctl.msg)    tx_src = TX_MSG;
        else                      tx_src = TX_NORMAL;

        if (slot_ctl.loc_lp)                    rx_src = RX_LOOP;
        else if (slot_ctl.rx_tst && dmw_sel)    rx_src = RX_TEST;
        else                                    rx_src = RX_NORMAL;
    end

    // Byte muxing
    always_comb begin
        unique case (tx_src)
            TX_LOOP:   tx_byte = line_rx_byte;
            TX_TEST:   tx_byte = dmw_sel ? tone_byte : prbs_byte;
            TX_MSG:    tx_byte = msg_byte;
            TX_NORMAL: tx_byte = slot_ctl.inv ? ~bp_tx_byte : bp_tx_byte;
        endcase
        tx_fin = (sig_frame && !slot_ctl.clr_ch) ? {tx_byte[7:1], sig_bit} : tx_byte;
        unique case (rx_src)
            RX_LOOP:   rx_byte = tx_fin;
            RX_TEST:   rx_byte = tone_byte;
            RX_NORMAL: rx_byte = slot_ctl.inv ? ~line_rx_byte : line_rx_byte;
            default:   rx_byte = line_rx_byte;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_tx_q  <= '0;
            bp_rx_q    <= '0;
            out_slot_q <= '0;
            vld_q      <= 1'b0;
        end else begin
            vld_q <= byte_vld;
            if (byte_vld) begin
                line_tx_q  <= tx_fin;
                bp_rx_q    <= rx_byte;
                out_slot_q <= slot_q;
            end
        end
    end

    assign line_tx_byte = line_tx_q;
    assign bp_rx_byte   = bp_rx_q;
    assign out_slot     = out_slot_q;
    assign out_vld      = vld_q;
endmodule

// File: rtl/tslot_ctl_path_chk.sv
module tslot_ctl_path_chk #(
    parameter int unsigned SLOTS = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_vld,
    input logic [4:0]  cfg_addr,
    input logic [7:0]  cfg_rdata,
    input logic [7:0]  msg_byte,
    input logic [7:0]  line_rx_byte,
    input logic        sig_ram_bit,
    input logic        err_clr,
    input logic [7:0]  line_tx_byte,
    input logic [7:0]  bp_rx_byte,
    input logic        out_vld,
    input logic [4:0]  out_slot,
    input logic [15:0] prbs_err_cnt,
    input logic [7:0]  cur_ctl,
    input logic        sig_frame
);
    AST_VLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> out_vld); // R13
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> (!out_vld && $stable(line_tx_byte) && $stable(bp_rx_byte))); // R13
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(out_slot) < SLOTS); // R13
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cfg_addr) >= SLOTS |-> cfg_rdata == 8'h00); // R2
    AST_MSG_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && cur_ctl[7] && !cur_ctl[5] && !cur_ctl[3] && (cur_ctl[0] || !sig_frame))
        |=> line_tx_byte == $past(msg_byte)); // R3
    AST_REM_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && cur_ctl[5] && cur_ctl[0]) |=> line_tx_byte == $past(line_rx_byte)); // R5
    AST_LOC_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && cur_ctl[4]) |=> bp_rx_byte == line_tx_byte); // R6
    AST_ROB_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && sig_frame && !cur_ctl[0] && cur_ctl[1]) |=> line_tx_byte[0] == $past(sig_ram_bit)); // R10
    AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> prbs_err_cnt == 16'h0000); // R12
    AST_ERR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> prbs_err_cnt >= $past(prbs_err_cnt)); // R12
endmodule

bind tslot_ctl_path tslot_ctl_path_chk #(.SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .msg_byte(msg_byte),
    .line_rx_byte(line_rx_byte), .sig_ram_bit(sig_ram_bit), .err_clr(err_clr),
    .line_tx_byte(line_tx_byte), .bp_rx_byte(bp_rx_byte), .out_vld(out_vld),
    .out_slot(out_slot), .prbs_err_cnt(prbs_err_cnt),
    .cur_ctl(slot_ctl), .sig_frame(sig_frame)
);

// File: tb/tslot_ctl_path_tb.sv
`timescale 1ns/1ps
module tslot_ctl_path_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  msg_byte = 8'h5A;
    logic        dmw_sel = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  bp_tx_byte = '0;
    logic [7:0]  line_rx_byte = '0;
    logic        sig_ser_bit = 1'b0;
    logic        sig_ram_bit = 1'b0;
    logic        err_clr = 1'b0;
    logic [7:0]  line_tx_byte, bp_rx_byte;
    logic        out_vld, prbs_locked;
    logic [4:0]  out_slot;
    logic [15:0] prbs_err_cnt;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tslot_ctl_path u_dut (.*);

    // reference model state
    logic [7:0]  m_ctl [24];
    int          m_slot = 0, m_f6 = 0, m_f8 = 0;
    logic [14:0] m_gen = '1;
    int          m_loaded = 0;
    logic [14:0] m_sh = '0;
    int          m_errs = 0;
    logic [7:0]  e_tx = 0, e_rx = 0;
    logic [4:0]  e_slot = 0;
    logic        e_vld = 0;
    string       tx_tag = "R1", rx_tag = "R1";
    logic [14:0] src = 15'h1234;

    function automatic logic [7:0] tone(int i);
        logic [7:0] t [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
        return t[i];
    endfunction

    function automatic logic [7:0] src_byte();
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            logic f;
            f = src[14] ^ src[13];
            b[7-i] = f;
            src = {src[13:0], f};
        end
        return b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model();
        logic [7:0] c, t, pb;
        logic sb;
        int nsrc;
        c = m_ctl[m_slot];
        if (byte_vld) begin
            pb = 0;
            if (c[3] && !dmw_sel) begin
                for (int i = 0; i < 8; i++) begin
                    logic f;
                    f = m_gen[14] ^ m_gen[13];
                    pb[7-i] = f;
                    m_gen = {m_gen[13:0], f};
                end
            end
            nsrc = int'(c[5]) + int'(c[3]) + int'(c[7]) + int'(c[6]);
            if (c[5])      begin t = line_rx_byte; tx_tag = "R5"; end
            else if (c[3]) begin t = dmw_sel ? tone(m_f8) : pb; tx_tag = "R7"; end
            else if (c[7]) begin t = msg_byte; tx_tag = "R3"; end
            else if (c[6]) begin t = ~bp_tx_byte; tx_tag = "R4"; end
            else           begin t = bp_tx_byte; tx_tag = "R13"; end
            if (nsrc > 1) tx_tag = "R11";
            if (m_f6 == 5 && !c[0]) begin
                sb = c[1] ? sig_ram_bit : sig_ser_bit;
                t[0] = sb;
                tx_tag = c[1] ? "R10 ram" : "R9 robbed";
            end
            e_tx = t;
            if (c[4])                begin e_rx = t; rx_tag = (c[6] || c[2]) ? "R11" : "R6"; end
            else if (c[2] && dmw_sel) begin e_rx = tone(m_f8); rx_tag = "R8"; end
            else if (c[6])           begin e_rx = ~line_rx_byte; rx_tag = "R4"; end
            else                     begin e_rx = line_rx_byte; rx_tag = "R13"; end
            if (c[2] && !dmw_sel) begin
                for (int i = 0; i < 8; i++) begin
                    logic bi;
                    bi = line_rx_byte[7-i];
                    if (m_loaded < 15) m_loaded++;
                    else if (bi != (m_sh[14] ^ m_sh[13]) && m_errs < 65535) m_errs++;
                    m_sh = {m_sh[13:0], bi};
                end
            end
            e_slot = 5'(m_slot);
            if (m_slot == 23) begin
                m_slot = 0;
                m_f6 = (m_f6 + 1) % 6;
                m_f8 = (m_f8 + 1) % 8;
            end else m_slot++;
        end
        if (err_clr) m_errs = 0;
        e_vld = byte_vld;
        if (cfg_we && cfg_addr < 24) m_ctl[cfg_addr] = cfg_wdata;
    endtask

    task automatic compare();
        chk("R13 out_vld", 32'(out_vld), 32'(e_vld));
        chk("R13 out_slot", 32'(out_slot), 32'(e_slot));
        chk({tx_tag, " line_tx"}, 32'(line_tx_byte), 32'(e_tx));
        chk({rx_tag, " bp_rx"}, 32'(bp_rx_byte), 32'(e_rx));
        chk("R12 err_cnt", 32'(prbs_err_cnt), 32'(m_errs));
        chk("R12 locked", 32'(prbs_locked), 32'(m_loaded >= 15));
    endtask

    task automatic step(input logic vld, input logic [7:0] bp, input logic [7:0] ln, input logic clr);
        byte_vld = vld; bp_tx_byte = bp; line_rx_byte = ln; err_clr = clr;
        sig_ser_bit = 1'($urandom); sig_ram_bit = 1'($urandom);
        model();
        @(posedge clk); @(negedge clk);
        byte_vld = 0; err_clr = 0; cfg_we = 0;
        compare();
    endtask

    task automatic cfg_wr(input logic [4:0] a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        step(0, 0, 0, 0);
    endtask

    task automatic cfg_rd(input logic [4:0] a, input logic [7:0] exp);
        cfg_addr = a; #1;
        chk("R2 readback", 32'(cfg_rdata), 32'(exp));
    endtask

    initial begin
        #(8 * 190000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 24; i++) m_ctl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 line_tx", 32'(line_tx_byte), 0);
        chk("R1 bp_rx", 32'(bp_rx_byte), 0);
        chk("R1 out_vld", 32'(out_vld), 0);
        chk("R1 out_slot", 32'(out_slot), 0);
        chk("R1 err_cnt", 32'(prbs_err_cnt), 0);
        chk("R1 locked", 32'(prbs_locked), 0);
        cfg_rd(5'd3, 8'h00);

        // R2 control table writes
        cfg_wr(1, 8'h80);  cfg_wr(2, 8'h40);  cfg_wr(3, 8'h20);
        cfg_wr(4, 8'h10);  cfg_wr(5, 8'h08);  cfg_wr(6, 8'h04);
        cfg_wr(7, 8'h02);  cfg_wr(8, 8'h01);  cfg_wr(9, 8'h88);
        cfg_wr(10, 8'hA0); cfg_wr(11, 8'h08); cfg_wr(12, 8'h50);
        cfg_wr(13, 8'h21);
        cfg_wr(30, 8'hFF);
        cfg_rd(5'd5, 8'h08);
        cfg_rd(5'd30, 8'h00);
        cfg_rd(5'd12, 8'h50);

        // Phase A: pseudo-random mode, clean then one flipped bit
        dmw_sel = 0;
        for (int f = 0; f < 12; f++) begin
            for (int s = 0; s < 24; s++) begin
                logic [7:0] ln;
                ln = (s == 6) ? src_byte() : 8'($urandom);
                if (s == 6 && f == 9) ln = ln ^ 8'h10;
                step(1, 8'($urandom), ln, 0);
            end
        end
        chk("R8 checker errors on one flip", 32'(prbs_err_cnt), 3);
        chk("R12 lock after load", 32'(prbs_locked), 1);
        step(0, 0, 0, 1);
        chk("R12 clear", 32'(prbs_err_cnt), 0);

        // Phase B: tone mode
        dmw_sel = 1;
        for (int f = 0; f < 9; f++)
            for (int s = 0; s < 24; s++)
                step(1, 8'($urandom), 8'($urandom), 0);
        step(0, 0, 0, 0);

        // Phase C: saturation with random data on every slot
        for (int i = 0; i < 24; i++) cfg_wr(5'(i), 8'h04);
        dmw_sel = 0;
        for (int f = 0; f < 1000; f++)
            for (int s = 0; s < 24; s++)
                step(1, 8'($urandom), 8'($urandom), 0);
        chk("R12 saturation", 32'(prbs_err_cnt), 32'hFFFF);
        step(1, 8'h00, 8'h00, 1);
        chk("R12 clear wins", 32'(prbs_err_cnt), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule